// File: doc/BRIEF.md
# Peripheral-to-Register-File DMA Channel

This block is one DMA channel that copies bytes between a single peripheral control register and a range of a 4K-byte register file. Software sets the direction, the step size, the peripheral register, and the start and end of the range through a small byte-wide configuration port. Each pulse on the trigger input then starts one transfer. For that transfer the channel asks for the system bus, waits until the bus is granted, moves one byte or one two-byte word, and gives the bus back.

A current-address register moves through the register-file range from the start address to the end address, one transfer at a time. When the transfer at the end address completes, the current address returns to the start address. At that point the channel can send a one-cycle interrupt pulse. In single-pass mode it also clears its own enable bit. A trigger that arrives while a transfer is in progress is held as a single pending request and is served once the bus has been released.

Top module: `dma_chan`

## Requirements
- R1: Registers are selected by `cfg_sel`: 0 = control, 1 = peripheral low address, 2 = start low byte, 3 = end low byte, 4 = high nibbles (bits [3:0] start, bits [7:4] end). Control bits: [0] enable, [1] direction (1 = register file to peripheral), [2] word step, [3] interrupt enable, [4] single-pass. `cfg_rdata` shows the selected register at all times; unused select values read 0. Everything is 0 after reset.
- R2: A trigger raises `bus_req`. No memory access takes place until `bus_gnt` is high. `bus_req` stays high for the whole transfer, word transfers included, and falls once the transfer is done.
- R3: With direction 0, every byte is first read from the peripheral address and then written to register-file address current+k. Each write is the value returned by the read just before it.
- R4: With direction 1, every byte is read from register-file address current+k and written to the peripheral address. Every peripheral address has 0xF as its upper nibble.
- R5: In byte mode the peripheral address is {F, low byte}. In word mode two bytes are moved in one bus tenure, low address first. The peripheral addresses are then {F, low[7:1], 0} and {F, low[7:1], 1}.
- R6: When a transfer completes and the current address differs from the end address, the current address rises by 1 in byte mode and by 2 in word mode.
- R7: When a transfer completes at the end address, the current address is loaded with the start address.
- R8: Completing the transfer at the end address gives a one-cycle `irq` pulse if interrupt enable is set. No pulse occurs otherwise.
- R9: In single-pass mode, completing the transfer at the end address clears the enable bit, which reads back as 0. Later triggers, including one pending at that moment, cause no transfer.
- R10: Writing the start low byte or the high register while the channel is disabled loads the current address from the updated start address.
- R11: At most one trigger received during a transfer is held. It is served after the bus is released, and extra triggers in that window are dropped.
- R12: While the channel is disabled, triggers cause neither a bus request nor any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register |
| trig | input | 1 | Transfer request, one per high cycle |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | 12 | Memory bus address |
| mem_rd | output | 1 | Read strobe; data is returned on `mem_rdata` in the following cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| irq | output | 1 | End-of-block interrupt pulse |

## Verification
Two events can land in the same cycle: a trigger can arrive during the transfer that completes a single-pass block, which is also the moment the self-disable clears the enable bit. The bench creates this case by withholding the grant, sending a second trigger while the first is still waiting, and then releasing the grant. The case is judged correct when exactly one byte is written and the enable bit reads back cleared, which shows that the pending request was dropped and not served.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int HW = AW - DW;
  localparam int SW = 3;

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_FIN} st_t;

  localparam logic [SW-1:0] SEL_CTRL  = 3'd0;
  localparam logic [SW-1:0] SEL_IO    = 3'd1;
  localparam logic [SW-1:0] SEL_START = 3'd2;
  localparam logic [SW-1:0] SEL_END   = 3'd3;
  localparam logic [SW-1:0] SEL_HIGH  = 3'd4;

  localparam int B_EN   = 0;
  localparam int B_DIR  = 1;
  localparam int B_WORD = 2;
  localparam int B_IE   = 3;
  localparam int B_SP   = 4;
  localparam int CTRL_W = 5;

  // next current address once a transfer has finished
  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] cur,
                                               input logic [AW-1:0] endv,
                                               input logic [AW-1:0] start,
                                               input logic word);
    if (cur == endv) return start;
    return cur + (word ? AW'(2) : AW'(1));
  endfunction

  // peripheral-side address for the byte currently being moved
  function automatic logic [AW-1:0] periph_addr(input logic [HW-1:0] page,
                                                input logic [DW-1:0] io,
                                                input logic word,
                                                input logic hi);
    if (word) return {page, io[DW-1:1], hi};
    return {page, io};
  endfunction
endpackage

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SW-1:0]     sel,
  input  logic [DW-1:0]     wdata,
  input  logic              clr_en,
  output logic [DW-1:0]     rdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DW-1:0]     io,
  output logic [AW-1:0]     start,
  output logic [AW-1:0]     endv,
  output logic              ld
);
  logic [DW-1:0] st_lo, end_lo, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      io     <= '0;
      st_lo  <= '0;
      end_lo <= '0;
      hi_q   <= '0;
      ld     <= 1'b0;
    end else begin
      ld <= 1'b0;
      if (wr) begin
        case (sel)
          SEL_CTRL:  ctrl <= wdata[CTRL_W-1:0];
          SEL_IO:    io <= wdata;
          SEL_START: begin st_lo <= wdata; ld <= !ctrl[B_EN]; end
          SEL_END:   end_lo <= wdata;
          SEL_HIGH:  begin hi_q <= wdata; ld <= !ctrl[B_EN]; end
          default: ;
        endcase
      end
      if (clr_en) ctrl[B_EN] <= 1'b0;
    end
  end

  assign start = {hi_q[HW-1:0], st_lo};
  assign endv  = {hi_q[DW-1:DW-HW], end_lo};

  always_comb begin
    case (sel)
      SEL_CTRL:  rdata = DW'(ctrl);
      SEL_IO:    rdata = io;
      SEL_START: rdata = st_lo;
      SEL_END:   rdata = end_lo;
      SEL_HIGH:  rdata = hi_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_walk.sv
module dma_chan_walk
  import dma_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          adv,
  input  logic          word,
  input  logic          hi,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] endv,
  output logic [AW-1:0] rf_addr,
  output logic          at_end
);
  logic [AW-1:0] cur;

  always_ff @(posedge clk) begin
    if (!rst_n)   cur <= '0;
    else if (ld)  cur <= start;
    else if (adv) cur <= addr_after(cur, endv, start, word);
  end

  assign at_end  = (cur == endv);
  assign rf_addr = cur + AW'(hi);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trig,
  input  logic gnt,
  input  logic word,
  output st_t  st,
  output logic hi,
  output logic req,
  output logic fin
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      hi   <= 1'b0;
      pend <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (en && (trig || pend)) st <= ST_REQ;
        ST_REQ:  if (gnt) st <= ST_RD;
        ST_RD:   st <= ST_WR;
        ST_WR:   if (word && !hi) begin hi <= 1'b1; st <= ST_RD; end
                 else st <= ST_FIN;
        ST_FIN:  begin hi <= 1'b0; st <= ST_IDLE; end
        default: st <= ST_IDLE;
      endcase
      if (!en || st == ST_IDLE) pend <= 1'b0;
      else if (trig)            pend <= 1'b1;
    end
  end

  assign req = (st == ST_REQ) || (st == ST_RD) || (st == ST_WR);
  assign fin = (st == ST_FIN);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter logic [HW-1:0] PAGE = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [SW-1:0] cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          trig,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [DW-1:0]     io;
  logic [AW-1:0]     start, endv, rf_addr, p_addr;
  logic              ld, at_end, hi, fin_evt, done_evt, clr_en, use_periph;
  logic              en_w, dir_w, word_w, sp_w;
  st_t               st;

  assign en_w   = ctrl[B_EN];
  assign dir_w  = ctrl[B_DIR];
  assign word_w = ctrl[B_WORD];
  assign sp_w   = ctrl[B_SP];

  dma_chan_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .clr_en(clr_en), .rdata(cfg_rdata), .ctrl(ctrl), .io(io),
    .start(start), .endv(endv), .ld(ld)
  );

  dma_chan_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en_w), .trig(trig), .gnt(bus_gnt),
    .word(word_w), .st(st), .hi(hi), .req(bus_req), .fin(fin_evt)
  );

  dma_chan_walk u_walk (
    .clk(clk), .rst_n(rst_n), .ld(ld), .adv(fin_evt), .word(word_w), .hi(hi),
    .start(start), .endv(endv), .rf_addr(rf_addr), .at_end(at_end)
  );

  assign done_evt   = fin_evt && at_end;
  assign clr_en     = done_evt && sp_w;
  assign irq        = done_evt && ctrl[B_IE];

  assign mem_rd     = (st == ST_RD);
  assign mem_wr     = (st == ST_WR);
  assign use_periph = mem_rd ^ dir_w;
  assign p_addr     = periph_addr(PAGE, io, word_w, hi);
  assign mem_addr   = (mem_rd || mem_wr) ? (use_periph ? p_addr : rf_addr) : '0;
  assign mem_wdata  = mem_wr ? mem_rdata : '0;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
  import dma_chan_pkg::*;
#(
  parameter logic [HW-1:0] PAGE = 4'hF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          irq,
  input logic          dir,
  input logic          en,
  input logic          done_evt,
  input logic          sp,
  input logic          cfg_wr,
  input logic [SW-1:0] cfg_sel
);
  // R2
  access_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  // R4
  periph_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && dir) |-> (mem_addr[AW-1:DW] == PAGE));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  irq_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(mem_wr) && !bus_req));

  // R9
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $past((done_evt && sp) || (cfg_wr && cfg_sel == SEL_CTRL)));
endmodule

bind dma_chan dma_chan_chk #(.PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .irq(irq),
  .dir(dir_w), .en(en_w), .done_evt(done_evt), .sp(sp_w),
  .cfg_wr(cfg_wr), .cfg_sel(cfg_sel)
);

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        trig = 1'b0;
  logic        bus_req, bus_gnt = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, irq;
  logic [7:0]  mem_wdata, mem_rdata = '0;

  logic        gnt_ok = 1'b1;
  logic        poke_en = 1'b0;
  logic [11:0] poke_a = '0;
  logic [7:0]  poke_d = '0;
  logic [7:0]  mem [4096];
  int          wr_cnt = 0, irq_cnt = 0, rise_cnt = 0;
  logic [11:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  logic        req_d = 1'b0;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig(trig),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    bus_gnt <= rst_n && bus_req && gnt_ok;
    req_d   <= bus_req;
    if (rst_n) begin
      if (mem_wr) begin
        wlog_a[wr_cnt % 64] <= mem_addr;
        wlog_d[wr_cnt % 64] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (irq) irq_cnt <= irq_cnt + 1;
      if (bus_req && !req_d) rise_cnt <= rise_cnt + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_sel = 3'd0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk); cfg_sel = sel; #1 d = cfg_rdata;
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] io,
                       input logic [7:0] hi, input logic [7:0] s, input logic [7:0] e);
    cfg(3'd0, 8'h00);
    cfg(3'd1, io);
    cfg(3'd4, hi);
    cfg(3'd2, s);
    cfg(3'd3, e);
    cfg(3'd0, c);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 bus_req after reset", bus_req, 0);
    check("R1 irq after reset", irq, 0);
    rd(3'd0, v); check("R1 control after reset", v, 8'h00);
    cfg(3'd1, 8'h5A); rd(3'd1, v); check("R1 io readback", v, 8'h5A);
    cfg(3'd0, 8'h1E); rd(3'd0, v); check("R1 control readback", v, 8'h1E);
    rd(3'd6, v); check("R1 unused select", v, 8'h00);
    cfg(3'd0, 8'h00);
  endtask

  task automatic t_p2r_walk;
    int i0;
    poke(12'h103, 8'hEE);
    poke(12'hF40, 8'h11);
    setup(8'h09, 8'h40, 8'h11, 8'h00, 8'h02);
    i0 = irq_cnt;
    pulse; run(20);
    check("R3 byte to rf start", mem[12'h100], 8'h11);
    check("R3 write address", wlog_a[(wr_cnt - 1) % 64], 12'h100);
    poke(12'hF40, 8'h22); pulse; run(20);
    check("R6 step by one", mem[12'h101], 8'h22);
    check("R8 no irq before end", irq_cnt - i0, 0);
    poke(12'hF40, 8'h33); pulse; run(20);
    check("R6 reaches end", mem[12'h102], 8'h33);
    check("R8 irq at end", irq_cnt - i0, 1);
    poke(12'hF40, 8'h44); pulse; run(20);
    check("R7 reload to start", mem[12'h100], 8'h44);
    check("R7 past end untouched", mem[12'h103], 8'hEE);
  endtask

  task automatic t_word_r2p;
    int b, r0, i0;
    poke(12'h200, 8'hA0); poke(12'h201, 8'hA1);
    poke(12'h202, 8'hA2); poke(12'h203, 8'hA3);
    setup(8'h07, 8'h21, 8'h22, 8'h00, 8'h02);
    b = wr_cnt; r0 = rise_cnt; i0 = irq_cnt;
    pulse; run(30);
    check("R5 two bytes per word", wr_cnt - b, 2);
    check("R5 low byte address", wlog_a[b % 64], 12'hF20);
    check("R4 low byte data", wlog_d[b % 64], 8'hA0);
    check("R5 high byte address", wlog_a[(b + 1) % 64], 12'hF21);
    check("R4 high byte data", wlog_d[(b + 1) % 64], 8'hA1);
    check("R2 single tenure", rise_cnt - r0, 1);
    pulse; run(30);
    check("R6 step by two lo", mem[12'hF20], 8'hA2);
    check("R6 step by two hi", mem[12'hF21], 8'hA3);
    check("R8 no irq when disabled", irq_cnt - i0, 0);
    pulse; run(30);
    check("R7 word reload", mem[12'hF20], 8'hA0);
  endtask

  task automatic t_grant_pending;
    int b;
    poke(12'hF40, 8'h5C);
    setup(8'h01, 8'h40, 8'h11, 8'h50, 8'hFF);
    gnt_ok = 1'b0; b = wr_cnt;
    pulse; run(15);
    check("R2 request held", bus_req, 1);
    check("R2 no access without grant", wr_cnt - b, 0);
    gnt_ok = 1'b1; run(20);
    check("R2 request released", bus_req, 0);
    check("R2 one byte after grant", wr_cnt - b, 1);
    gnt_ok = 1'b0; b = wr_cnt;
    pulse; run(3); pulse; run(2); pulse; pulse;
    gnt_ok = 1'b1; run(60);
    check("R11 one pending kept", wr_cnt - b, 2);
    check("R11 pending address", wlog_a[(b + 1) % 64], 12'h152);
  endtask

  task automatic t_disabled;
    int b, r0;
    cfg(3'd0, 8'h00);
    b = wr_cnt; r0 = rise_cnt;
    pulse; run(20);
    check("R12 no access when disabled", wr_cnt - b, 0);
    check("R12 no request when disabled", rise_cnt - r0, 0);
  endtask

  task automatic t_start_load;
    setup(8'h01, 8'h40, 8'h00, 8'h50, 8'hFF);
    pulse; run(20);
    check("R10 first address", wlog_a[(wr_cnt - 1) % 64], 12'h050);
    pulse; run(20);
    check("R6 second address", wlog_a[(wr_cnt - 1) % 64], 12'h051);
    cfg(3'd0, 8'h00); cfg(3'd2, 8'h60); cfg(3'd0, 8'h01);
    pulse; run(20);
    check("R10 reload on start write", wlog_a[(wr_cnt - 1) % 64], 12'h060);
  endtask

  task automatic t_single_pass;
    int b, i0;
    logic [7:0] v;
    setup(8'h19, 8'h40, 8'h33, 8'h00, 8'h00);
    b = wr_cnt; i0 = irq_cnt;
    pulse; run(20);
    check("R9 one byte moved", wr_cnt - b, 1);
    check("R9 irq at end", irq_cnt - i0, 1);
    rd(3'd0, v); check("R9 enable cleared", v, 8'h18);
    pulse; run(20);
    check("R9 later trigger ignored", wr_cnt - b, 1);
    // pending trigger meets the self-disable
    setup(8'h11, 8'h40, 8'h33, 8'h10, 8'h10);
    gnt_ok = 1'b0; b = wr_cnt;
    pulse; run(3); pulse;
    gnt_ok = 1'b1; run(40);
    check("R9 pending dropped at self-disable", wr_cnt - b, 1);
    rd(3'd0, v); check("R9 enable cleared again", v, 8'h10);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run(4);
    rst_n = 1'b1;
    run(2);
    t_reset;
    t_p2r_walk;
    t_word_r2p;
    t_grant_pending;
    t_disabled;
    t_start_load;
    t_single_pass;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule